// File: doc/BRIEF.md
# Multiprocessor UART Receive Address Filter

This block sits behind the bit-level deserializer of a UART running 9-bit frames. Each time the deserializer finishes a frame, it presents the data byte, the ninth bit and the sampled stop bit with a one-cycle strobe. The block then decides whether the frame is accepted. An accepted frame latches its byte into a receive buffer and raises a sticky receive flag. Separately, the block records a sticky framing error whenever the stop bit is low.

In multiprocessor mode, only frames whose ninth bit is 1 count as address frames, and they are accepted only when they match this node. A frame can match in two ways. The first is the node's given address: an individual address register, with don't-care positions marked by zeros in a mask register. The second is the broadcast address, formed as address OR mask. Both registers reset to zero, so a freshly reset node answers to every address. The framing-error flag can be read in the position that normally holds mode select bit 0, when the error enable is set.

Top module: `uart_rx_addr_filter`

## Requirements
- R1: After reset, rxFlag and frameErr are 0, rxData is 0x00, and address and mask registers are 0x00, so in multiprocessor mode any address frame (ninth bit 1) is accepted.
- R2: A given-address match exists when (rxByte AND mask) equals (address AND mask).
- R3: A broadcast match exists when every bit set in (address OR mask) is also set in rxByte; bits that are 0 in (address OR mask) are don't-care.
- R4: A frameDone with stopBit=0 sets frameErr in the following cycle.
- R5: frameErr stays set until frameErrClr or reset; a frame with a valid stop bit never clears it, and a new error in the same cycle as frameErrClr leaves it set.
- R6: ctrlBit0 shows frameErr when errFlagEn is 1, and modeBit0In when errFlagEn is 0.
- R7: With multiProcEn=1 and rxBit9=1, a frame sets rxFlag and loads rxData in the next cycle only on a given-address or broadcast match.
- R8: With multiProcEn=1 and rxBit9=0, a frame leaves rxFlag and rxData unchanged.
- R9: With multiProcEn=0, every frame sets rxFlag and loads rxData in the next cycle, regardless of address.
- R10: rxFlagClr clears rxFlag in the next cycle; an accepted frame in the same cycle leaves rxFlag set.
- R11: A write through addrWrEn or maskWrEn of cfgWrData affects matching from the next cycle onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrData | input | 8 | Write data for the address or mask register |
| addrWrEn | input | 1 | Load the individual address register |
| maskWrEn | input | 1 | Load the mask register |
| frameDone | input | 1 | One-cycle strobe: a frame is complete |
| rxByte | input | 8 | Received data byte |
| rxBit9 | input | 1 | Received ninth bit |
| stopBit | input | 1 | Sampled stop bit (1 = valid) |
| multiProcEn | input | 1 | Multiprocessor address filtering enable |
| errFlagEn | input | 1 | Selects frameErr onto ctrlBit0 |
| modeBit0In | input | 1 | Stored mode select bit 0 |
| rxFlagClr | input | 1 | Clear request for rxFlag |
| frameErrClr | input | 1 | Clear request for frameErr |
| rxFlag | output | 1 | Sticky receive flag |
| frameErr | output | 1 | Sticky framing-error flag |
| rxData | output | 8 | Last accepted byte |
| ctrlBit0 | output | 1 | Shared control bit view: frameErr or mode bit 0 |

## Verification
The assertions assume that frameDone is a single-cycle pulse whose companion inputs are stable in that cycle. They also assume that a clear request is a level sampled at the clock, not an edge. The stimulus drives every input once per cycle, away from the rising edge, and raises frameDone for exactly one cycle per frame. Clears and register writes are placed both apart from frames and in the same cycle as frames. This exercises the set-over-clear priority and the one-cycle delay before a new address or mask takes effect.

// File: rtl/uart_rx_filter_pkg.sv
package uart_rx_filter_pkg;
  localparam int DATA_W = 8;

  typedef struct packed {
    logic loadData;
    logic setRx;
    logic setFe;
  } rxStrobes_t;
endpackage

// File: rtl/uart_rx_filter_dp.sv
module uart_rx_filter_dp
  import uart_rx_filter_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] cfgWrData,
  input  logic         addrWrEn,
  input  logic         maskWrEn,
  input  logic [W-1:0] rxByte,
  input  rxStrobes_t   strobes,
  output logic         givenHit,
  output logic         bcastHit,
  output logic [W-1:0] rxData
);
  localparam logic [W-1:0] ZERO = '0;

  logic [W-1:0] addrReg;
  logic [W-1:0] maskReg;
  logic [W-1:0] bcastAddr;
  logic [W-1:0] givenBitOk;
  logic [W-1:0] bcastBitOk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg <= ZERO;
      maskReg <= ZERO;
    end else begin
      if (addrWrEn) addrReg <= cfgWrData;
      if (maskWrEn) maskReg <= cfgWrData;
    end
  end

  assign bcastAddr = addrReg | maskReg;

  // Per-bit match terms: a position passes if it is don't-care or agrees.
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign givenBitOk[i] = !maskReg[i] || (rxByte[i] == addrReg[i]);
    assign bcastBitOk[i] = !bcastAddr[i] || rxByte[i];
  end

  assign givenHit = &givenBitOk;
  assign bcastHit = &bcastBitOk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                rxData <= ZERO;
    else if (strobes.loadData) rxData <= rxByte;
  end

  // R1: registers at zero accept any address through the given match
  p_reset_accepts_r1: assert property (@(posedge clk) disable iff (!rstN)
    ((addrReg == ZERO) && (maskReg == ZERO)) |-> givenHit);

  // R11: a write lands in the register one cycle later
  p_addr_write_r11: assert property (@(posedge clk) disable iff (!rstN)
    addrWrEn |=> (addrReg == $past(cfgWrData)));

  // R2: given match must imply equality under the mask
  p_given_match_r2: assert property (@(posedge clk) disable iff (!rstN)
    givenHit |-> ((rxByte & maskReg) == (addrReg & maskReg)));
endmodule

// File: rtl/uart_rx_filter_ctl.sv
module uart_rx_filter_ctl
  import uart_rx_filter_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       frameDone,
  input  logic       rxBit9,
  input  logic       stopBit,
  input  logic       multiProcEn,
  input  logic       errFlagEn,
  input  logic       modeBit0In,
  input  logic       rxFlagClr,
  input  logic       frameErrClr,
  input  logic       givenHit,
  input  logic       bcastHit,
  output rxStrobes_t strobes,
  output logic       rxFlag,
  output logic       frameErr,
  output logic       ctrlBit0
);
  logic addrOk;
  logic accept;

  assign addrOk = rxBit9 && (givenHit || bcastHit);
  assign accept = frameDone && (!multiProcEn || addrOk);

  always_comb begin
    strobes          = '0;
    strobes.loadData = accept;
    strobes.setRx    = accept;
    strobes.setFe    = frameDone && !stopBit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxFlag   <= 1'b0;
      frameErr <= 1'b0;
    end else begin
      if (strobes.setRx)  rxFlag <= 1'b1;
      else if (rxFlagClr) rxFlag <= 1'b0;
      if (strobes.setFe)    frameErr <= 1'b1;
      else if (frameErrClr) frameErr <= 1'b0;
    end
  end

  assign ctrlBit0 = errFlagEn ? frameErr : modeBit0In;

  // R4
  p_fe_set_r4: assert property (@(posedge clk) disable iff (!rstN)
    (frameDone && !stopBit) |=> frameErr);
  // R5
  p_fe_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
    (frameErr && !frameErrClr) |=> frameErr);
  // R8
  p_ninth_zero_ignored_r8: assert property (@(posedge clk) disable iff (!rstN)
    (frameDone && multiProcEn && !rxBit9 && !rxFlag) |=> !rxFlag);
  // R9
  p_plain_mode_r9: assert property (@(posedge clk) disable iff (!rstN)
    (frameDone && !multiProcEn) |=> rxFlag);
  // R10
  p_rx_clear_r10: assert property (@(posedge clk) disable iff (!rstN)
    (rxFlagClr && !frameDone) |=> !rxFlag);
  // R7
  p_mismatch_ignored_r7: assert property (@(posedge clk) disable iff (!rstN)
    (frameDone && multiProcEn && !givenHit && !bcastHit && !rxFlag) |=> !rxFlag);
endmodule

// File: rtl/uart_rx_addr_filter.sv
module uart_rx_addr_filter
  import uart_rx_filter_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] cfgWrData,
  input  logic              addrWrEn,
  input  logic              maskWrEn,
  input  logic              frameDone,
  input  logic [DATA_W-1:0] rxByte,
  input  logic              rxBit9,
  input  logic              stopBit,
  input  logic              multiProcEn,
  input  logic              errFlagEn,
  input  logic              modeBit0In,
  input  logic              rxFlagClr,
  input  logic              frameErrClr,
  output logic              rxFlag,
  output logic              frameErr,
  output logic [DATA_W-1:0] rxData,
  output logic              ctrlBit0
);
  rxStrobes_t strobes;
  logic       givenHit;
  logic       bcastHit;

  uart_rx_filter_dp #(.W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .cfgWrData(cfgWrData), .addrWrEn(addrWrEn),
    .maskWrEn(maskWrEn), .rxByte(rxByte), .strobes(strobes),
    .givenHit(givenHit), .bcastHit(bcastHit), .rxData(rxData)
  );

  uart_rx_filter_ctl u_ctl (
    .clk(clk), .rstN(rstN), .frameDone(frameDone), .rxBit9(rxBit9),
    .stopBit(stopBit), .multiProcEn(multiProcEn), .errFlagEn(errFlagEn),
    .modeBit0In(modeBit0In), .rxFlagClr(rxFlagClr), .frameErrClr(frameErrClr),
    .givenHit(givenHit), .bcastHit(bcastHit), .strobes(strobes),
    .rxFlag(rxFlag), .frameErr(frameErr), .ctrlBit0(ctrlBit0)
  );
endmodule

// File: tb/uart_rx_addr_filter_tb.sv
module uart_rx_addr_filter_tb;
  logic clk = 0, rstN = 0;
  logic [7:0] cfgWrData = 0, rxByte = 0;
  logic addrWrEn = 0, maskWrEn = 0, frameDone = 0, rxBit9 = 0, stopBit = 1;
  logic multiProcEn = 0, errFlagEn = 0, modeBit0In = 0, rxFlagClr = 0, frameErrClr = 0;
  logic rxFlag, frameErr, ctrlBit0;
  logic [7:0] rxData;

  int errors = 0, checks = 0, cycles = 0;
  bit done = 0;
  string curReq = "R1";

  // behavioural reference state
  int mAddr = 0, mMask = 0, mRx = 0, mFe = 0, mData = 0;

  always #10 clk = ~clk;

  uart_rx_addr_filter u_dut (
    .clk(clk), .rstN(rstN), .cfgWrData(cfgWrData), .addrWrEn(addrWrEn),
    .maskWrEn(maskWrEn), .frameDone(frameDone), .rxByte(rxByte), .rxBit9(rxBit9),
    .stopBit(stopBit), .multiProcEn(multiProcEn), .errFlagEn(errFlagEn),
    .modeBit0In(modeBit0In), .rxFlagClr(rxFlagClr), .frameErrClr(frameErrClr),
    .rxFlag(rxFlag), .frameErr(frameErr), .rxData(rxData), .ctrlBit0(ctrlBit0)
  );

  always @(posedge clk) begin
    int b, bc;
    bit given, bcast, acc;
    if (!rstN) begin
      mAddr = 0; mMask = 0; mRx = 0; mFe = 0; mData = 0;
    end else begin
      b = rxByte;
      given = ((b & mMask) == (mAddr & mMask));
      bc = mAddr | mMask;
      bcast = ((b & bc) == bc);
      acc = frameDone && (!multiProcEn || (rxBit9 && (given || bcast)));
      if (acc) begin mRx = 1; mData = b; end
      else if (rxFlagClr) mRx = 0;
      if (frameDone && !stopBit) mFe = 1;
      else if (frameErrClr) mFe = 0;
      if (addrWrEn) mAddr = cfgWrData;
      if (maskWrEn) mMask = cfgWrData;
    end
  end

  task automatic cmp(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", curReq, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rstN) begin
      cmp("rxFlag", rxFlag, mRx);
      cmp("frameErr", frameErr, mFe);
      cmp("rxData", rxData, mData);
      cmp("ctrlBit0", ctrlBit0, errFlagEn ? mFe : modeBit0In);
    end
    if (cycles > 5000 && !done) begin
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic step();
    @(negedge clk); #1;
    frameDone = 0; addrWrEn = 0; maskWrEn = 0; rxFlagClr = 0; frameErrClr = 0;
  endtask

  task automatic frame(input logic [7:0] b, input logic n9, input logic stp);
    @(negedge clk); #1;
    frameDone = 1; rxByte = b; rxBit9 = n9; stopBit = stp;
    step();
  endtask

  task automatic wrReg(input logic isMask, input logic [7:0] v);
    @(negedge clk); #1;
    cfgWrData = v; addrWrEn = !isMask; maskWrEn = isMask;
    step();
  endtask

  task automatic clrRx();
    @(negedge clk); #1; rxFlagClr = 1; step();
  endtask

  task automatic expectFlag(input string req, input int act, input int exp);
    curReq = req;
    cmp("explicit", act, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 rstN = 1;
    @(negedge clk); #2;
    expectFlag("R1", rxFlag, 0);
    expectFlag("R1", frameErr, 0);
    expectFlag("R1", rxData, 0);
    // R1: any address accepted after reset in multiprocessor mode
    multiProcEn = 1;
    frame(8'hC3, 1, 1); #2;
    expectFlag("R1", rxFlag, 1);
    expectFlag("R1", rxData, 8'hC3);
    clrRx(); #2;
    expectFlag("R10", rxFlag, 0);
    // R11 + R2: given address 0x5A, mask 0xF0 -> upper nibble 5 required
    curReq = "R11";
    wrReg(0, 8'h5A);
    wrReg(1, 8'hF0);
    curReq = "R2";
    frame(8'h53, 1, 1); #2;
    expectFlag("R2", rxFlag, 1);
    clrRx();
    frame(8'h6A, 1, 1); #2;          // no given; bcast=0xFA needs bits set
    expectFlag("R2", rxFlag, 0);
    // R3: broadcast 0xFA: byte 0xFF matches, 0xFB matches, 0xF8 does not
    frame(8'hFF, 1, 1); #2;
    expectFlag("R3", rxFlag, 1);
    expectFlag("R3", rxData, 8'hFF);
    clrRx();
    frame(8'hF8, 1, 1); #2;
    expectFlag("R3", rxFlag, 0);
    frame(8'hFB, 1, 1); #2;
    expectFlag("R3", rxFlag, 1);
    clrRx();
    // R8: ninth bit 0 ignored in multiprocessor mode
    frame(8'h55, 0, 1); #2;
    expectFlag("R8", rxFlag, 0);
    expectFlag("R8", rxData, 8'hFB);
    // R9: plain mode accepts everything
    multiProcEn = 0;
    frame(8'h12, 0, 1); #2;
    expectFlag("R9", rxFlag, 1);
    expectFlag("R9", rxData, 8'h12);
    // R10: clear with simultaneous accepted frame keeps flag set
    @(negedge clk); #1; frameDone = 1; rxByte = 8'h34; rxFlagClr = 1; step(); #2;
    expectFlag("R10", rxFlag, 1);
    // R4 / R6: framing error and its shared view
    modeBit0In = 1; errFlagEn = 0;
    frame(8'h00, 0, 0); #2;
    expectFlag("R4", frameErr, 1);
    expectFlag("R6", ctrlBit0, 1);
    modeBit0In = 0; #1;
    expectFlag("R6", ctrlBit0, 0);
    errFlagEn = 1; #1;
    expectFlag("R6", ctrlBit0, 1);
    // R5: valid frames do not clear, clear with new error keeps set
    frame(8'h01, 0, 1); #2;
    expectFlag("R5", frameErr, 1);
    @(negedge clk); #1; frameDone = 1; stopBit = 0; frameErrClr = 1; step(); #2;
    expectFlag("R5", frameErr, 1);
    stopBit = 1;
    @(negedge clk); #1; frameErrClr = 1; step(); #2;
    expectFlag("R5", frameErr, 0);
    expectFlag("R6", ctrlBit0, 0);
    // R11: write and frame in the same cycle uses old address
    multiProcEn = 1; clrRx();
    wrReg(1, 8'hFF);                 // mask all: given = 0x5A exactly, bcast = 0xFF
    @(negedge clk); #1; frameDone = 1; rxByte = 8'h5A; rxBit9 = 1;
    cfgWrData = 8'h11; addrWrEn = 1; step(); #2;
    expectFlag("R11", rxFlag, 1);
    clrRx();
    frame(8'h5A, 1, 1); #2;
    expectFlag("R11", rxFlag, 0);
    frame(8'h11, 1, 1); #2;
    expectFlag("R7", rxFlag, 1);
    expectFlag("R7", rxData, 8'h11);
    repeat (3) step();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule